// File: doc/BRIEF.md
# I2C Receive Interrupt and Clock-Stretch Sequencer

This block decides when a byte-oriented I2C interface interrupts its processor and when it holds the bus clock low. It samples the raw SCL and SDA lines into the system clock domain and detects clock falls, START and STOP. It counts the bits of each byte and issues a one-cycle interrupt pulse at the chosen points. At each such point it clears an active-low pending flag and requests that SCL be held low. Software releases the bus by writing the pending flag back to 1.

Every byte interrupts on the fall of its acknowledge clock. A received data byte can also interrupt one bit earlier, on the fall of its last data bit, so that software can decide on the acknowledge before the acknowledge clock runs. This early point applies only when acknowledge mode and the early-interrupt enable are both set. There the acknowledge clock is also inhibited until software restarts the bus. A wait flag records which of the two points is current. A data-register write sets it and a clock-control write clears it. A STOP condition can raise an interrupt of its own without touching the pending flag.

Top module: `i2c_rx_irq_seq`

## Requirements
- R1: After reset the pending flag `pend_n` is 1 and `irq`, `scl_hold`, `ack_inhibit` and `wait_flag` are 0.
- R2: On the ninth counted SCL fall of every byte (the acknowledge clock), `irq` pulses, `pend_n` goes to 0 and `scl_hold` goes to 1.
- R3: When `ack_mode`=1 and `early_rx_en`=1 and a data byte is received (`is_transmit`=0, not the address byte), the eighth counted SCL fall pulses `irq`, clears `pend_n` and sets both `scl_hold` and `ack_inhibit`.
- R4: The eighth counted fall raises no interrupt for a transmitted byte, for the address byte, or when `ack_mode`=0, whatever `early_rx_en` is.
- R5: A `wr_data` strobe during the early stall leaves `pend_n`, `scl_hold` and `ack_inhibit` unchanged.
- R6: A `wr_pend_set` strobe sets `pend_n` to 1 and drops `scl_hold` and `ack_inhibit`. After a restart from the early point, the acknowledge fall interrupts again and clears `pend_n`.
- R7: `wait_flag` is set by `wr_data` only while the early point is enabled for a received data byte, and is cleared by `wr_clkctl`. It stays 0 for transmitted bytes.
- R8: A STOP (SDA rising while SCL is high) pulses `irq` when `stop_irq_en`=1 and does not change `pend_n`. When `stop_irq_en`=0 it raises no interrupt.
- R9: A START (SDA falling while SCL is high) restarts the bit count. The SCL fall that completes the START is not counted, and the following byte is treated as the address byte.
- R10: `irq` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| is_transmit | input | 1 | Current byte is sent by this interface |
| ack_mode | input | 1 | Acknowledge bit of the clock-control register |
| early_rx_en | input | 1 | Enable for the interrupt at the last data bit |
| stop_irq_en | input | 1 | Enable for the interrupt on STOP |
| wr_data | input | 1 | Write strobe for the data shift register |
| wr_clkctl | input | 1 | Write strobe for the clock-control register |
| wr_pend_set | input | 1 | Write strobe that sets the pending flag to 1 |
| irq | output | 1 | One-cycle interrupt request |
| pend_n | output | 1 | Active-low pending flag |
| scl_hold | output | 1 | Request to hold SCL low |
| ack_inhibit | output | 1 | Acknowledge clock generation blocked |
| wait_flag | output | 1 | Internal wait flag, read back through the early-enable bit |

## Verification
A change on `scl_in` or `sda_in` passes two synchronizer stages and one edge-detect register. So `irq`, `pend_n`, `scl_hold` and `ack_inhibit` change on the third rising clock edge after the line moves. Each watched SCL fall is driven just after a falling clock edge. The bench then requires `irq` to be low at the sample after the second rising edge and at its expected value at the sample after the third. Register-write strobes take effect on the one rising edge during which they are high, and the bench samples one cycle later. A monitor counts every interrupt pulse at falling edges, so counts per byte and per STOP are compared without depending on when in the cycle the pulse falls.

// File: rtl/i2c_irq_pkg.sv
// Shared definitions for the I2C interrupt sequencer.
// Assumes: one system clock domain for everything that uses these types.
package i2c_irq_pkg;

    // Bus events detected on synchronized lines, each valid for one cycle.
    typedef struct packed {
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

endpackage

// File: rtl/i2c_bus_sync.sv
// Brings SCL/SDA into the clock domain and flags clock falls, START and STOP.
// Assumes: SYNC_STAGES >= 2; idle lines are high, so the chains reset to 1.
module i2c_bus_sync
    import i2c_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_raw,
    input  logic     sda_raw,
    output bus_evt_t evt
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_chain;
    logic [LAST:0] sda_chain;
    logic          scl_prev;
    logic          sda_prev;
    logic          scl_now;
    logic          sda_now;

    // Synchronizer shift chains plus one-cycle history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_prev  <= 1'b1;
            sda_prev  <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[LAST-1:0], scl_raw};
            sda_chain <= {sda_chain[LAST-1:0], sda_raw};
            scl_prev  <= scl_chain[LAST];
            sda_prev  <= sda_chain[LAST];
        end
    end

    assign scl_now = scl_chain[LAST];
    assign sda_now = sda_chain[LAST];

    // Edge and condition decode from the current and previous samples.
    always_comb begin
        evt.scl_fall = scl_prev & ~scl_now;
        evt.start    = scl_prev & scl_now & sda_prev & ~sda_now;
        evt.stop     = scl_prev & scl_now & ~sda_prev & sda_now;
    end
endmodule

// File: rtl/i2c_bit_tracker.sv
// Counts SCL falls within a byte and marks the last-data and acknowledge falls.
// Assumes: the fall that ends a START is not a bit; the first byte after START
// is the address byte.
module i2c_bit_tracker
    import i2c_irq_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  bus_evt_t evt,
    output logic     last_data_fall,
    output logic     ack_fall,
    output logic     addr_byte
);
    localparam int CW = $clog2(DATA_BITS + 1);
    localparam logic [CW-1:0] LAST_DATA = CW'(DATA_BITS - 1);
    localparam logic [CW-1:0] ACK_SLOT  = CW'(DATA_BITS);

    logic [CW-1:0] bit_cnt;
    logic          skip_fall;
    logic          counted_fall;

    assign counted_fall   = evt.scl_fall & ~skip_fall;
    assign last_data_fall = counted_fall & (bit_cnt == LAST_DATA);
    assign ack_fall       = counted_fall & (bit_cnt == ACK_SLOT);

    // Bit position, START skip marker and address-byte marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            skip_fall <= 1'b0;
            addr_byte <= 1'b0;
        end else if (evt.start) begin
            bit_cnt   <= '0;
            skip_fall <= 1'b1;
            addr_byte <= 1'b1;
        end else if (evt.scl_fall) begin
            if (skip_fall) begin
                skip_fall <= 1'b0;
            end else if (bit_cnt == ACK_SLOT) begin
                bit_cnt   <= '0;
                addr_byte <= 1'b0;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_irq_sequencer.sv
// Issues interrupts, keeps the pending flag, stall state and wait flag.
// Assumes: write strobes last one cycle; early point only in ACK mode.
module i2c_irq_sequencer (
    input  logic clk,
    input  logic rst_n,
    input  logic last_data_fall,
    input  logic ack_fall,
    input  logic stop_seen,
    input  logic addr_byte,
    input  logic is_transmit,
    input  logic ack_mode,
    input  logic early_rx_en,
    input  logic stop_irq_en,
    input  logic wr_data,
    input  logic wr_clkctl,
    input  logic wr_pend_set,
    output logic irq,
    output logic pend_n,
    output logic scl_hold,
    output logic ack_inhibit,
    output logic wait_flag
);
    logic early_ok;
    logic early_hit;
    logic ack_stall;

    assign early_ok  = ack_mode & early_rx_en & ~is_transmit & ~addr_byte;
    assign early_hit = last_data_fall & early_ok;
    assign scl_hold  = ack_inhibit | ack_stall;

    // Interrupt pulse for the early point, acknowledge fall or enabled STOP.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= early_hit | ack_fall | (stop_seen & stop_irq_en);
    end

    // Pending flag: cleared at stretch points, set only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                      pend_n <= 1'b1;
        else if (early_hit | ack_fall)   pend_n <= 1'b0;
        else if (wr_pend_set)            pend_n <= 1'b1;
    end

    // Stall state for the two stretch points.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_inhibit <= 1'b0;
            ack_stall   <= 1'b0;
        end else if (early_hit) begin
            ack_inhibit <= 1'b1;
        end else if (ack_fall) begin
            ack_inhibit <= 1'b0;
            ack_stall   <= 1'b1;
        end else if (wr_pend_set) begin
            ack_inhibit <= 1'b0;
            ack_stall   <= 1'b0;
        end
    end

    // Wait flag: marks that the early point is armed for this data byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                    wait_flag <= 1'b0;
        else if (wr_clkctl)            wait_flag <= 1'b0;
        else if (wr_data & early_ok)   wait_flag <= 1'b1;
    end
endmodule

// File: rtl/i2c_rx_irq_seq.sv
// Top: I2C interrupt and clock-stretch sequencer.
// Assumes: raw lines may be asynchronous; all outputs are registered.
module i2c_rx_irq_seq
    import i2c_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DATA_BITS   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic is_transmit,
    input  logic ack_mode,
    input  logic early_rx_en,
    input  logic stop_irq_en,
    input  logic wr_data,
    input  logic wr_clkctl,
    input  logic wr_pend_set,
    output logic irq,
    output logic pend_n,
    output logic scl_hold,
    output logic ack_inhibit,
    output logic wait_flag
);
    bus_evt_t evt;
    logic     last_data_fall;
    logic     ack_fall;
    logic     addr_byte;

    i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in), .evt(evt)
    );

    i2c_bit_tracker #(.DATA_BITS(DATA_BITS)) u_bits (
        .clk(clk), .rst_n(rst_n), .evt(evt),
        .last_data_fall(last_data_fall), .ack_fall(ack_fall), .addr_byte(addr_byte)
    );

    i2c_irq_sequencer u_seq (
        .clk(clk), .rst_n(rst_n),
        .last_data_fall(last_data_fall), .ack_fall(ack_fall), .stop_seen(evt.stop),
        .addr_byte(addr_byte), .is_transmit(is_transmit), .ack_mode(ack_mode),
        .early_rx_en(early_rx_en), .stop_irq_en(stop_irq_en),
        .wr_data(wr_data), .wr_clkctl(wr_clkctl), .wr_pend_set(wr_pend_set),
        .irq(irq), .pend_n(pend_n), .scl_hold(scl_hold),
        .ack_inhibit(ack_inhibit), .wait_flag(wait_flag)
    );
endmodule

// File: rtl/i2c_rx_irq_seq_chk.sv
// Checker for the sequencer's port behaviour, bound to the top module.
module i2c_rx_irq_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_data,
    input logic wr_pend_set,
    input logic irq,
    input logic pend_n,
    input logic scl_hold,
    input logic ack_inhibit,
    input logic wait_flag
);
    // R2: the pending flag only falls together with an interrupt pulse.
    assert_pend_fall_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_n) |-> irq);

    // R2: a held clock always comes with a cleared pending flag.
    assert_hold_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold |-> !pend_n);

    // R3: the acknowledge inhibit starts with an interrupt.
    assert_inhibit_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_inhibit) |-> irq);

    // R6: the pending flag rises only after a pending-set write.
    assert_pend_rise_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_n) |-> $past(wr_pend_set));

    // R7: the wait flag rises only after a data-register write.
    assert_wait_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wait_flag) |-> $past(wr_data));

    // R10: interrupt is a single-cycle pulse.
    assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

bind i2c_rx_irq_seq i2c_rx_irq_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_pend_set(wr_pend_set),
    .irq(irq), .pend_n(pend_n), .scl_hold(scl_hold),
    .ack_inhibit(ack_inhibit), .wait_flag(wait_flag)
);

// File: tb/i2c_rx_irq_seq_bench.sv
// Bench: directed corner cases plus seeded random frames.
module i2c_rx_irq_seq_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1, sda_in = 1'b1;
    logic is_transmit = 1'b0, ack_mode = 1'b0, early_rx_en = 1'b0, stop_irq_en = 1'b0;
    logic wr_data = 1'b0, wr_clkctl = 1'b0, wr_pend_set = 1'b0;
    logic irq, pend_n, scl_hold, ack_inhibit, wait_flag;

    int checks = 0;
    int errs = 0;
    int irq_total = 0;
    int pulse_bad = 0;
    logic irq_prev = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    i2c_rx_irq_seq u_i2c_rx_irq_seq (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .is_transmit(is_transmit), .ack_mode(ack_mode), .early_rx_en(early_rx_en),
        .stop_irq_en(stop_irq_en), .wr_data(wr_data), .wr_clkctl(wr_clkctl),
        .wr_pend_set(wr_pend_set), .irq(irq), .pend_n(pend_n), .scl_hold(scl_hold),
        .ack_inhibit(ack_inhibit), .wait_flag(wait_flag)
    );

    // Interrupt pulse monitor (R10 length, and counting for R2/R3/R4/R8).
    always @(negedge clk) begin
        if (irq) irq_total++;
        if (irq && irq_prev) pulse_bad++;
        irq_prev = irq;
    end

    function automatic bit f_early(bit tx, bit addr, bit ack, bit en);
        return ack && en && !tx && !addr;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sw_strobe(int kind);
        @(negedge clk);
        case (kind)
            0: wr_data = 1'b1;
            1: wr_clkctl = 1'b1;
            default: wr_pend_set = 1'b1;
        endcase
        @(negedge clk);
        wr_data = 1'b0; wr_clkctl = 1'b0; wr_pend_set = 1'b0;
        wait_n(1);
    endtask

    // SCL fall with cycle-exact check of the interrupt (third edge after drive).
    task automatic fall_watch(int exp_irq, string req);
        @(negedge clk); scl_in = 1'b0;
        @(negedge clk);
        @(negedge clk); chk(req, irq, 0);
        @(negedge clk); chk(req, irq, exp_irq);
        wait_n(2);
    endtask

    task automatic clock_bit(bit b, bit watch, int exp_irq, string req);
        @(negedge clk); sda_in = b;
        wait_n(2);
        scl_in = 1'b1;
        wait_n(4);
        if (watch) fall_watch(exp_irq, req);
        else begin scl_in = 1'b0; wait_n(4); end
    endtask

    task automatic data_bits(int exp_early, string req);
        for (int i = 0; i < 8; i++)
            clock_bit(1'($urandom), i == 7, exp_early, req);
    endtask

    task automatic bus_start;
        @(negedge clk);
        if (!scl_in) begin sda_in = 1'b1; wait_n(2); scl_in = 1'b1; wait_n(4); end
        sda_in = 1'b0; wait_n(4);
        scl_in = 1'b0; wait_n(4);
    endtask

    task automatic bus_stop;
        @(negedge clk); sda_in = 1'b0; wait_n(2);
        scl_in = 1'b1; wait_n(4);
        sda_in = 1'b1; wait_n(6);
    endtask

    task automatic release_bus;
        sw_strobe(2);
        chk("R6 pend_n after release", pend_n, 1);
        chk("R6 scl_hold after release", scl_hold, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
            $finish;
        end
    end

    initial begin
        int base;
        void'($urandom(32'd1234));
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        // R1 reset state
        chk("R1 pend_n", pend_n, 1);
        chk("R1 irq", irq, 0);
        chk("R1 scl_hold", scl_hold, 0);
        chk("R1 ack_inhibit", ack_inhibit, 0);
        chk("R1 wait_flag", wait_flag, 0);

        // Address byte received with early enable on: only the ACK point (R9, R4, R2).
        ack_mode = 1'b1; early_rx_en = 1'b1;
        bus_start();
        chk("R9 START fall not counted", irq_total, 0);
        data_bits(0, "R4/R9 address byte no early irq");
        sw_strobe(0);
        chk("R7 wait stays 0 in address byte", wait_flag, 0);
        clock_bit(1'b0, 1'b1, 1, "R2 ack fall irq");
        chk("R2 pend_n cleared", pend_n, 0);
        chk("R2 scl_hold set", scl_hold, 1);
        release_bus();

        // Received data byte with early point (R7, R3, R5, R6).
        sw_strobe(0);
        chk("R7 wait set by data write", wait_flag, 1);
        data_bits(1, "R3 early irq");
        chk("R3 pend_n cleared", pend_n, 0);
        chk("R3 scl_hold", scl_hold, 1);
        chk("R3 ack_inhibit", ack_inhibit, 1);
        sw_strobe(0);
        chk("R5 hold kept after data write", scl_hold, 1);
        chk("R5 pend kept after data write", pend_n, 0);
        chk("R5 inhibit kept", ack_inhibit, 1);
        sw_strobe(1);
        chk("R7 wait cleared by clkctl write", wait_flag, 0);
        release_bus();
        chk("R6 inhibit dropped", ack_inhibit, 0);
        clock_bit(1'b0, 1'b1, 1, "R6 second irq at ack fall");
        chk("R6 pend_n cleared again", pend_n, 0);

        // STOP while pending is 0, with stop interrupt on (R8).
        stop_irq_en = 1'b1;
        base = irq_total;
        bus_stop();
        chk("R8 stop irq", irq_total - base, 1);
        chk("R8 pend_n unchanged", pend_n, 0);
        release_bus();

        // Transmit byte: no early irq, wait stays 0 (R4, R7).
        bus_start();
        data_bits(0, "R9 address byte");
        clock_bit(1'b0, 1'b1, 1, "R2 ack fall");
        release_bus();
        is_transmit = 1'b1;
        sw_strobe(0);
        chk("R7 wait 0 when transmitting", wait_flag, 0);
        data_bits(0, "R4 transmit no early irq");
        clock_bit(1'b1, 1'b1, 1, "R2 transmit ack irq");
        release_bus();

        // NACK mode receive: early enable ignored (R4).
        is_transmit = 1'b0; ack_mode = 1'b0;
        data_bits(0, "R4 nack no early irq");
        clock_bit(1'b1, 1'b1, 1, "R2 ack irq in nack");
        release_bus();

        // STOP with interrupt disabled (R8).
        stop_irq_en = 1'b0;
        base = irq_total;
        bus_stop();
        chk("R8 no irq when disabled", irq_total - base, 0);
        chk("R8 pend_n unchanged 1", pend_n, 1);

        // Seeded random frames.
        for (int f = 0; f < 10; f++) begin
            bus_start();
            is_transmit = 1'b0;
            data_bits(0, "R9 random address");
            clock_bit(1'b0, 1'b1, 1, "R2 random addr ack");
            release_bus();
            for (int b = 0; b < 3; b++) begin
                bit tx, ak, en, ex;
                tx = 1'($urandom); ak = 1'($urandom); en = 1'($urandom);
                ex = f_early(tx, 1'b0, ak, en);
                is_transmit = tx; ack_mode = ak; early_rx_en = en;
                sw_strobe(0);
                chk("R7 random wait", wait_flag, ex);
                data_bits(ex, "R3/R4 random early point");
                if (ex) begin
                    chk("R3 random hold", scl_hold, 1);
                    sw_strobe(1);
                    chk("R7 random wait clear", wait_flag, 0);
                    release_bus();
                end
                clock_bit(1'($urandom), 1'b1, 1, "R2 random ack point");
                chk("R2 random pend", pend_n, 0);
                release_bus();
            end
            stop_irq_en = 1'($urandom);
            base = irq_total;
            bus_stop();
            chk("R8 random stop", irq_total - base, stop_irq_en ? 1 : 0);
        end

        chk("R10 irq pulse length violations", pulse_bad, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end
endmodule